// File: doc/BRIEF.md
# Serial Boot Record Parser

This block sits behind a serial configuration-memory reader. It takes an in-order byte stream on a valid/ready interface, where each byte comes with its stream index. It decodes a ten-byte header into static configuration outputs: memory size, boot clock, serial clock, memory length class, subsystem and vendor identifiers, and PLL control bytes. A mode bit in the header picks one of two flows. In host-assisted mode, parsing ends after the header. In autonomous mode, the block reads an 11-bit record byte count. It then assembles 8-byte address/value records from the stream, most significant byte first, and issues each record as a write on a request/acknowledge port.

Record addresses follow a fixed pattern. The first record must target a fixed window-relocation address, and its value becomes the new window base. The next three records must target base + 0x100000, base + 0x100004 and base + 0x100008, in that order. Any later record may target any address. A broken pattern or an out-of-order byte index stops parsing and raises a sticky error. Normal completion gives a one-cycle done pulse. After done or error, the block accepts and discards all further input until reset.

Top module: `boot_rec_parser`

## Requirements
- R1: Bit 7 of header byte 1 selects the mode: 0 = host-assisted, 1 = autonomous. In host-assisted mode, `done_o` pulses in the cycle after byte 9 is accepted, and no write is issued.
- R2: Byte 0 bits [6:4] give the memory size on `mem_mb_o`: codes 0 and 1 give 1 MB, and codes 2..7 give 2, 4, 8, 16, 32 and 64 MB.
- R3: Byte 0 bits [3:2] give the boot clock on `boot_mhz_o`: 0 = 100, 1 = 75, 2 = 50, 3 = 33. Byte 0 bit 1 gives the serial clock on `ser_khz_o`: 0 = 100, 1 = 400.
- R4: Byte 0 bit 7 drives `long_mem_o`. Bytes 2/3 form the subsystem ID and bytes 4/5 form the vendor ID, each high byte first. Byte 6 drives `pll_ctrl_o` and byte 7 drives `pll_ratio_o`.
- R5: In autonomous mode, bits [2:0] of byte 10 and all of byte 11 form the 11-bit record byte count. The count covers the bytes after index 11. A count of 0 ends parsing right after byte 11. A trailing partial record produces no write.
- R6: Each record is 8 bytes: a 32-bit address, then a 32-bit value, each most significant byte first. Records start at index 12. Each complete valid record issues exactly one write, in stream order.
- R7: The first record's address must be 0xEFF00400. Its value becomes the window base.
- R8: Records 2, 3 and 4 must target base + 0x100000, base + 0x100004 and base + 0x100008. Later records may target any address.
- R9: When an address breaks R7 or R8, `err_o` rises and stays high, the write for that record is not issued, and no later write is issued.
- R10: `wr_addr_o` and `wr_data_o` stay stable while `wr_req_o` is high and not acknowledged. `byte_ready_o` is low while a write is pending.
- R11: `done_o` pulses once, in the cycle after the last counted byte is accepted, or after the final write is acknowledged when the last byte completes a record. After done, input is accepted and ignored: no write, no error, and no output change.
- R12: A byte whose index differs from the expected stream position sets the sticky error, and `done_o` does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_valid_i | input | 1 | Stream byte valid |
| byte_ready_o | output | 1 | Stream byte ready |
| byte_i | input | 8 | Stream byte |
| byte_idx_i | input | IDX_W | Stream position of the byte |
| wr_req_o | output | 1 | Register write request |
| wr_addr_o | output | W | Write address |
| wr_data_o | output | W | Write data |
| wr_ack_i | input | 1 | Write acknowledge |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky parse error |
| auto_mode_o | output | 1 | Autonomous mode selected |
| long_mem_o | output | 1 | Memory holds 256 or more lines |
| mem_mb_o | output | 7 | Decoded memory size in MB |
| boot_mhz_o | output | 7 | Decoded boot clock in MHz |
| ser_khz_o | output | 9 | Decoded serial clock in kHz |
| subsys_id_o | output | 16 | Subsystem ID |
| subsys_vendor_o | output | 16 | Subsystem vendor ID |
| pll_ctrl_o | output | 8 | PLL control byte |
| pll_ratio_o | output | 8 | PLL ratio byte |

## Verification
The bench builds the block with its default parameters: 32-bit words, three fixed follow-on records, and a 12-bit index. Under that configuration, every header code combination fits in a full sweep. So do record counts from zero to six combined with write-acknowledge delays from zero to three cycles. Error injection at each fixed record position, an out-of-order index, a trailing partial record and input after completion are all reachable in short streams.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_WRITE, ST_DONE, ST_HALT, ST_ERR
  } state_e;

  localparam int HDR_LAST  = 9;
  localparam int CNT_HI    = 10;
  localparam int CNT_LO    = 11;
  localparam int REC_FIRST = 12;

  function automatic logic [6:0] mem_mb(input logic [2:0] code);
    if (code <= 3'd1) return 7'd1;
    return 7'd1 << (code - 3'd1);
  endfunction

  function automatic logic [6:0] boot_mhz(input logic [1:0] code);
    case (code)
      2'd0:    return 7'd100;
      2'd1:    return 7'd75;
      2'd2:    return 7'd50;
      default: return 7'd33;
    endcase
  endfunction
endpackage

// File: rtl/boot_hdr_dec.sv
module boot_hdr_dec #(
  parameter int IDX_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  output logic             auto_mode_o,
  output logic             long_mem_o,
  output logic [6:0]       mem_mb_o,
  output logic [6:0]       boot_mhz_o,
  output logic [8:0]       ser_khz_o,
  output logic [15:0]      subsys_id_o,
  output logic [15:0]      subsys_vendor_o,
  output logic [7:0]       pll_ctrl_o,
  output logic [7:0]       pll_ratio_o
);
  import boot_pkg::*;

  logic [2:0] size_q;
  logic [1:0] bclk_q;
  logic       fast_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_mode_o     <= 1'b0;
      long_mem_o      <= 1'b0;
      size_q          <= '0;
      bclk_q          <= '0;
      fast_q          <= 1'b0;
      subsys_id_o     <= '0;
      subsys_vendor_o <= '0;
      pll_ctrl_o      <= '0;
      pll_ratio_o     <= '0;
    end else if (stb_i) begin
      case (idx_i)
        IDX_W'(0): begin
          long_mem_o <= data_i[7];
          size_q     <= data_i[6:4];
          bclk_q     <= data_i[3:2];
          fast_q     <= data_i[1];
        end
        IDX_W'(1): auto_mode_o           <= data_i[7];
        IDX_W'(2): subsys_id_o[15:8]     <= data_i;
        IDX_W'(3): subsys_id_o[7:0]      <= data_i;
        IDX_W'(4): subsys_vendor_o[15:8] <= data_i;
        IDX_W'(5): subsys_vendor_o[7:0]  <= data_i;
        IDX_W'(6): pll_ctrl_o            <= data_i;
        IDX_W'(7): pll_ratio_o           <= data_i;
        default: ;
      endcase
    end
  end

  assign mem_mb_o   = mem_mb(size_q);
  assign boot_mhz_o = boot_mhz(bclk_q);
  assign ser_khz_o  = fast_q ? 9'd400 : 9'd100;
endmodule

// File: rtl/boot_rec_asm.sv
module boot_rec_asm #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic [7:0]   byte_i,
  output logic [W-1:0] word_o,  // word ending with the current byte
  output logic [W-1:0] head_o   // word that began seven bytes back
);
  localparam int SH_W = 2 * W - 8;

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (shift_i) sh_q <= {sh_q[SH_W-9:0], byte_i};
  end

  assign word_o = {sh_q[W-9:0], byte_i};
  assign head_o = sh_q[SH_W-1 -: W];
endmodule

// File: rtl/boot_addr_chk.sv
module boot_addr_chk #(
  parameter int          W        = 32,
  parameter int          N_FIX    = 3,
  parameter int          RN_W     = 3,
  parameter logic [31:0] WIN_ADDR = 32'hEFF0_0400,
  parameter logic [31:0] FIX_OFF  = 32'h0010_0000,
  parameter int          FIX_STEP = 4
) (
  input  logic [RN_W-1:0] rec_no_i,
  input  logic [W-1:0]    base_i,
  input  logic [W-1:0]    addr_i,
  output logic            ok_o
);
  logic [N_FIX:1] hit;

  for (genvar k = 1; k <= N_FIX; k++) begin : g_fix
    localparam logic [W-1:0] OFF = W'(FIX_OFF) + W'(FIX_STEP * (k - 1));
    assign hit[k] = (rec_no_i == RN_W'(k)) && (addr_i == base_i + OFF);
  end

  always_comb begin
    if (rec_no_i == '0)                ok_o = (addr_i == W'(WIN_ADDR));
    else if (rec_no_i > RN_W'(N_FIX)) ok_o = 1'b1;
    else                               ok_o = |hit;
  end
endmodule

// File: rtl/boot_wr_port.sv
module boot_wr_port #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         launch_i,
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] data_i,
  input  logic         ack_i,
  output logic         req_o,
  output logic [W-1:0] addr_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o  <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else if (launch_i) begin
      req_o  <= 1'b1;
      addr_o <= addr_i;
      data_o <= data_i;
    end else if (ack_i) begin
      req_o <= 1'b0;
    end
  end

  p_hold_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(addr_o) && $stable(data_o));
endmodule

// File: rtl/boot_rec_parser.sv
module boot_rec_parser #(
  parameter int          IDX_W    = 12,
  parameter int          CNT_W    = 11,
  parameter int          W        = 32,
  parameter int          N_FIX    = 3,
  parameter logic [31:0] WIN_ADDR = 32'hEFF0_0400,
  parameter logic [31:0] FIX_OFF  = 32'h0010_0000,
  parameter int          FIX_STEP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  input  logic [7:0]       byte_i,
  input  logic [IDX_W-1:0] byte_idx_i,
  output logic             wr_req_o,
  output logic [W-1:0]     wr_addr_o,
  output logic [W-1:0]     wr_data_o,
  input  logic             wr_ack_i,
  output logic             done_o,
  output logic             err_o,
  output logic             auto_mode_o,
  output logic             long_mem_o,
  output logic [6:0]       mem_mb_o,
  output logic [6:0]       boot_mhz_o,
  output logic [8:0]       ser_khz_o,
  output logic [15:0]      subsys_id_o,
  output logic [15:0]      subsys_vendor_o,
  output logic [7:0]       pll_ctrl_o,
  output logic [7:0]       pll_ratio_o
);
  import boot_pkg::*;

  localparam int CH_W      = CNT_W - 8;
  localparam int REC_B     = 2 * W / 8;
  localparam int LANE_W    = $clog2(REC_B);
  localparam int RN_W      = $clog2(N_FIX + 2);
  localparam logic [LANE_W-1:0] ADDR_LANE = LANE_W'(W / 8 - 1);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(REC_B - 1);
  localparam logic [IDX_W-1:0]  P_HDR = IDX_W'(HDR_LAST);
  localparam logic [IDX_W-1:0]  P_CHI = IDX_W'(CNT_HI);
  localparam logic [IDX_W-1:0]  P_CLO = IDX_W'(CNT_LO);
  localparam logic [IDX_W-1:0]  P_REC = IDX_W'(REC_FIRST);

  state_e            state_q;
  logic [IDX_W-1:0]  pos_q;
  logic [LANE_W-1:0] lane_q;
  logic [CNT_W-1:0]  rem_q;
  logic [CH_W-1:0]   cnt_hi_q;
  logic [RN_W-1:0]   rec_no_q;
  logic [W-1:0]      base_q;

  logic         take, idx_ok, in_rec, launch, addr_ok;
  logic [W-1:0] word, head;

  assign byte_ready_o = (state_q != ST_WRITE);
  assign done_o       = (state_q == ST_DONE);
  assign err_o        = (state_q == ST_ERR);

  assign idx_ok = (byte_idx_i == pos_q);
  assign take   = (state_q == ST_RUN) && byte_valid_i && idx_ok;
  assign in_rec = take && (pos_q >= P_REC);
  assign launch = in_rec && (lane_q == LAST_LANE);

  boot_hdr_dec #(.IDX_W(IDX_W)) u_hdr (
    .clk_i, .rst_ni,
    .stb_i           (take && (pos_q <= P_HDR)),
    .idx_i           (byte_idx_i),
    .data_i          (byte_i),
    .auto_mode_o, .long_mem_o, .mem_mb_o, .boot_mhz_o, .ser_khz_o,
    .subsys_id_o, .subsys_vendor_o, .pll_ctrl_o, .pll_ratio_o
  );

  boot_rec_asm #(.W(W)) u_asm (
    .clk_i, .rst_ni,
    .shift_i (in_rec),
    .byte_i,
    .word_o  (word),
    .head_o  (head)
  );

  boot_addr_chk #(
    .W(W), .N_FIX(N_FIX), .RN_W(RN_W),
    .WIN_ADDR(WIN_ADDR), .FIX_OFF(FIX_OFF), .FIX_STEP(FIX_STEP)
  ) u_chk (
    .rec_no_i (rec_no_q),
    .base_i   (base_q),
    .addr_i   (word),
    .ok_o     (addr_ok)
  );

  boot_wr_port #(.W(W)) u_wr (
    .clk_i, .rst_ni,
    .launch_i (launch),
    .addr_i   (head),
    .data_i   (word),
    .ack_i    (wr_ack_i),
    .req_o    (wr_req_o),
    .addr_o   (wr_addr_o),
    .data_o   (wr_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RUN;
      pos_q    <= '0;
      lane_q   <= '0;
      rem_q    <= '0;
      cnt_hi_q <= '0;
      rec_no_q <= '0;
      base_q   <= '0;
    end else begin
      case (state_q)
        ST_RUN: if (byte_valid_i) begin
          if (!idx_ok) state_q <= ST_ERR;
          else begin
            pos_q <= pos_q + 1'b1;
            if (pos_q == P_HDR && !auto_mode_o) state_q <= ST_DONE;
            else if (pos_q == P_CHI) cnt_hi_q <= byte_i[CH_W-1:0];
            else if (pos_q == P_CLO) begin
              rem_q <= {cnt_hi_q, byte_i};
              if ({cnt_hi_q, byte_i} == '0) state_q <= ST_DONE;
            end else if (pos_q >= P_REC) begin
              lane_q <= lane_q + 1'b1;
              rem_q  <= rem_q - 1'b1;
              if (lane_q == ADDR_LANE && !addr_ok) state_q <= ST_ERR;
              else if (lane_q == LAST_LANE) begin
                state_q <= ST_WRITE;
                if (rec_no_q == '0) base_q <= word;
                if (rec_no_q <= RN_W'(N_FIX)) rec_no_q <= rec_no_q + 1'b1;
              end else if (rem_q == CNT_W'(1)) state_q <= ST_DONE;
            end
          end
        end
        ST_WRITE: if (wr_ack_i) state_q <= (rem_q == '0) ? ST_DONE : ST_RUN;
        ST_DONE:  state_q <= ST_HALT;
        default:  ;
      endcase
    end
  end

  p_stall_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> !byte_ready_o);
  p_done_pulse_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !err_o);
  p_ignore_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HALT |=> state_q == ST_HALT && !wr_req_o && $stable(mem_mb_o));
  p_err_sticky_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o && !wr_req_o);
  p_idx_err_r12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RUN && byte_valid_i && byte_idx_i != pos_q |=> err_o);
  p_excl_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
endmodule

// File: tb/boot_rec_parser_tb.sv
module boot_rec_parser_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  data = '0;
  logic [11:0] idx = '0;
  logic        ack = 1'b0;
  logic        ready, req, done, err, auto_m, long_m;
  logic [31:0] waddr, wdata;
  logic [6:0]  mb, mhz;
  logic [8:0]  khz;
  logic [15:0] sid, vid;
  logic [7:0]  pctl, prat;

  always #10 clk = ~clk;

  boot_rec_parser u_dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(valid), .byte_ready_o(ready),
    .byte_i(data), .byte_idx_i(idx), .wr_req_o(req), .wr_addr_o(waddr),
    .wr_data_o(wdata), .wr_ack_i(ack), .done_o(done), .err_o(err),
    .auto_mode_o(auto_m), .long_mem_o(long_m), .mem_mb_o(mb), .boot_mhz_o(mhz),
    .ser_khz_o(khz), .subsys_id_o(sid), .subsys_vendor_o(vid),
    .pll_ctrl_o(pctl), .pll_ratio_o(prat)
  );

  int n_chk = 0, n_bad = 0;
  int bytes_sent, done_cnt, done_at, n_wr, ack_dly, wcnt, stab_bad;
  logic [31:0] log_a [0:15];
  logic [31:0] log_d [0:15];
  logic [31:0] exp_a [0:15];
  logic [31:0] exp_d [0:15];
  int n_exp;
  logic [7:0] img [0:255];
  int len;
  logic [31:0] hold_a, hold_d;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    summary();
  end

  // done monitor
  initial forever begin
    @(negedge clk);
    if (rst_n && done) begin done_cnt++; done_at = bytes_sent; end
  end

  // write responder with stability checking (R10)
  initial forever begin
    @(negedge clk);
    if (ack) ack = 1'b0;
    else if (rst_n && req) begin
      if (wcnt == 0) begin hold_a = waddr; hold_d = wdata; end
      else if (waddr != hold_a || wdata != hold_d) stab_bad++;
      if (ready) stab_bad++;
      if (wcnt >= ack_dly) begin
        if (n_wr < 16) begin log_a[n_wr] = waddr; log_d[n_wr] = wdata; end
        n_wr++; ack = 1'b1; wcnt = 0;
      end else wcnt++;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; valid = 1'b0;
    repeat (2) @(negedge clk);
    bytes_sent = 0; done_cnt = 0; done_at = -1; n_wr = 0; wcnt = 0; stab_bad = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input int i, input logic [7:0] b);
    @(negedge clk);
    valid = 1'b1; data = b; idx = 12'(i);
    while (!ready) @(negedge clk);
    @(posedge clk);
    bytes_sent++;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic run(input int bad_at);
    for (int i = 0; i < len; i++) send((i == bad_at) ? i + 1 : i, img[i]);
    repeat (12) @(negedge clk);
  endtask

  task automatic hdr(input logic [7:0] b0, input bit au, input logic [15:0] s,
                     input logic [15:0] v, input logic [7:0] pc, input logic [7:0] pr);
    img[0] = b0; img[1] = {au, 7'h55};
    img[2] = s[15:8]; img[3] = s[7:0]; img[4] = v[15:8]; img[5] = v[7:0];
    img[6] = pc; img[7] = pr; img[8] = 8'hA5; img[9] = 8'h5A;
    len = 10; n_exp = 0;
  endtask

  task automatic set_count(input int c);
    img[10] = {5'b10101, 3'(c >> 8)}; img[11] = 8'(c);
    if (len < 12) len = 12;
  endtask

  task automatic add_rec(input logic [31:0] a, input logic [31:0] d, input bit good);
    for (int k = 0; k < 4; k++) img[len + k] = 8'(a >> (24 - 8 * k));
    for (int k = 0; k < 4; k++) img[len + 4 + k] = 8'(d >> (24 - 8 * k));
    len += 8;
    if (good) begin exp_a[n_exp] = a; exp_d[n_exp] = d; n_exp++; end
  endtask

  // build: nrec records, bad_k = record whose address is corrupted (-1 none)
  task automatic build_auto(input int nrec, input logic [31:0] base, input int bad_k);
    logic [31:0] a;
    bit ok_so_far;
    hdr(8'h3C, 1'b1, 16'h1234, 16'h5678, 8'h9A, 8'hBC);
    len = 12;
    ok_so_far = 1'b1;
    for (int r = 0; r < nrec; r++) begin
      if (r == 0) a = 32'hEFF0_0400;
      else if (r <= 3) a = base + 32'h0010_0000 + 32'(4 * (r - 1));
      else a = 32'h4000_0000 + 32'(r * 16);
      if (r == bad_k) begin a = a + 32'h10; ok_so_far = 1'b0; end
      add_rec(a, (r == 0) ? base : 32'hD000_0000 + 32'(r), ok_so_far);
    end
    set_count(nrec * 8);
  endtask

  task automatic cmp_writes(input string rq);
    chk(n_wr == n_exp, rq, n_wr, n_exp);
    for (int j = 0; j < n_exp && j < n_wr; j++) begin
      chk(log_a[j] == exp_a[j], rq, log_a[j], exp_a[j]);
      chk(log_d[j] == exp_d[j], rq, log_d[j], exp_d[j]);
    end
  endtask

  initial begin
    ack_dly = 0;
    do_reset();
    chk(ready == 1'b1, "R10 reset ready", ready, 1);
    chk(done == 1'b0 && err == 1'b0 && req == 1'b0, "R11 reset state", {done, err, req}, 0);

    // header sweep, host-assisted (R1-R4)
    for (int c = 0; c < 64; c++) begin
      logic [2:0] sz; logic [1:0] bc; bit fs;
      int emb, emhz;
      sz = 3'(c >> 3); bc = 2'(c >> 1); fs = c[0];
      do_reset();
      hdr({c[2], sz, bc, fs, 1'b1}, 1'b0, 16'(16'hA000 + c * 3), 16'(16'h0B00 + c), 8'(c * 5), 8'(255 - c));
      run(-1);
      emb = (sz <= 1) ? 1 : (1 << (sz - 1));
      emhz = (bc == 0) ? 100 : (bc == 1) ? 75 : (bc == 2) ? 50 : 33;
      chk(mb == 7'(emb), "R2 mem size", mb, emb);
      chk(mhz == 7'(emhz), "R3 boot clock", mhz, emhz);
      chk(khz == (fs ? 9'd400 : 9'd100), "R3 serial clock", khz, fs ? 400 : 100);
      chk(long_m == c[2] && sid == 16'(16'hA000 + c * 3) && vid == 16'(16'h0B00 + c),
          "R4 ids", {long_m, sid, vid}, {c[2], 16'(16'hA000 + c * 3), 16'(16'h0B00 + c)});
      chk(pctl == 8'(c * 5) && prat == 8'(255 - c), "R4 pll", {pctl, prat}, {8'(c * 5), 8'(255 - c)});
      chk(auto_m == 1'b0 && done_cnt == 1 && done_at == 10 && n_wr == 0 && err == 1'b0,
          "R1 host done", {done_cnt, done_at}, {32'd1, 32'd10});
    end

    // host mode: trailing input ignored (R11)
    do_reset();
    hdr(8'h5E, 1'b0, 16'h1111, 16'h2222, 8'h33, 8'h44);
    img[10] = 8'h07; img[11] = 8'hFF; img[12] = 8'hEF; len = 13;
    run(-1);
    chk(done_cnt == 1 && err == 0 && n_wr == 0 && mb == 7'd16 && ready == 1'b1,
        "R11 ignore after done", {done_cnt, err, n_wr}, {32'd1, 1'b0, 32'd0});

    // autonomous sweep over record counts and ack delays (R5-R8, R10, R11)
    for (int nrec = 0; nrec <= 6; nrec++)
      for (int d = 0; d < 4; d++) begin
        ack_dly = d;
        do_reset();
        build_auto(nrec, 32'h1000_0000 + 32'(nrec << 24) + 32'(d << 16), -1);
        run(-1);
        chk(auto_m == 1'b1 && err == 1'b0, "R1 auto mode", {auto_m, err}, 2'b10);
        cmp_writes("R6 R7 R8 writes");
        chk(stab_bad == 0, "R10 held and stalled", stab_bad, 0);
        chk(done_cnt == 1 && done_at == len, "R11 done", {done_cnt, done_at}, {32'd1, 32'(len)});
        if (nrec == 0) chk(done_at == 12, "R5 zero count", done_at, 12);
      end

    // partial trailing record (R5)
    ack_dly = 1;
    do_reset();
    build_auto(3, 32'h2000_0000, -1);
    img[len] = 8'h11; img[len + 1] = 8'h22; img[len + 2] = 8'h33; len += 3;
    set_count(27);
    run(-1);
    cmp_writes("R5 partial");
    chk(done_cnt == 1 && done_at == len && err == 0, "R5 partial done", done_at, len);

    // bad address at each fixed position (R7-R9)
    for (int k = 0; k <= 3; k++) begin
      ack_dly = k;
      do_reset();
      build_auto(6, 32'h3000_0000, k);
      run(-1);
      cmp_writes(k == 0 ? "R7 bad first" : "R8 bad fixed");
      chk(err == 1'b1 && done_cnt == 0, "R9 error sticky", {err, done_cnt}, {1'b1, 32'd0});
    end

    // out-of-order index (R12)
    ack_dly = 0;
    do_reset();
    build_auto(2, 32'h5000_0000, -1);
    n_exp = 0;
    run(5);
    chk(err == 1'b1 && done_cnt == 0 && n_wr == 0, "R12 index error", {err, done_cnt, n_wr}, {1'b1, 32'd0, 32'd0});
    do_reset();
    build_auto(3, 32'h6000_0000, -1);
    n_exp = 1;
    run(21);
    chk(err == 1'b1 && done_cnt == 0, "R12 index error in record", {err, done_cnt}, {1'b1, 32'd0});
    cmp_writes("R12 writes before error");

    summary();
  end
endmodule